// File: doc/BRIEF.md
# Log/Antilog Galois Field Arithmetic Unit

This block adds and multiplies elements of GF(2^m). Each operand is an m-bit vector in polynomial basis. Addition is carry-free: each coefficient is summed modulo 2, which is a bitwise XOR.

Multiplication does not use a multiplier array. Each operand is first turned into its exponent of the primitive element alpha by a log table. The two exponents are added modulo 2^m-1, and an antilog table turns the sum back into a vector. Both tables have 2^m entries and are computed from the primitive polynomial when the design is elaborated. For m=8 the two tables hold 510 useful symbols. A full add matrix and a full multiply matrix would need 130,050. The zero element has no logarithm, so it is detected and handled separately.

The unit takes one operation per cycle and has a fixed two-stage pipeline. Error-correction encoders and decoders can issue a stream of mixed sums and products into it.

Top module: `gf_logalu`

## Requirements
- R1: With opSel=0 (add), the result is opA XOR opB.
- R2: With opSel=1 (multiply) and both operands nonzero, the result is antilog((log opA + log opB) mod 2^m-1). This equals the polynomial product of the operands reduced by the primitive polynomial.
- R3: A multiply in which either operand is zero gives zero.
- R4: An exponent sum of 2^m-1 or more is brought back into range by a single subtraction of 2^m-1. For m=8: alpha^254 times alpha^254 gives alpha^253, and alpha times alpha^254 gives 1.
- R5: outValid rises exactly two clock cycles after the cycle in which inValid was sampled high. While rstN is low, outValid is 0.
- R6: For m=3 with x^3+x+1 (PRIM_POLY=4'hB), start from 1 and multiply by 2 (alpha) again and again. The products are 2, 4, 3, 6, 7, 5, then 1.
- R7: A multiply by the vector 1 returns the other operand unchanged.
- R8: In GF(8), alpha times (alpha^3 + alpha^5) cubed evaluates to 1 when built as a chain of adds and multiplies through the unit.
- R9: outResult keeps its last value in every cycle in which no operation completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Operation present on the inputs this cycle |
| opSel | input | 1 | 0 = add, 1 = multiply |
| opA | input | SYM_W | First operand, vector form |
| opB | input | SYM_W | Second operand, vector form |
| outValid | output | 1 | Result of the operation issued two cycles earlier |
| outResult | output | SYM_W | Result in vector form, held between operations |

## Verification
The pipeline can hold an add and a multiply at the same time. While one operation has its operands turned into exponents in the first stage, the previous one has its exponents summed and turned back into a vector in the second stage. The stimulus issues back-to-back operations with a randomly chosen add or multiply on every cycle, so adds and multiplies overlap in both orders. Every completed result is checked against its own operation, using an XOR or a shift-and-XOR reference product.

// File: rtl/gf_logalu_pkg.sv
package gf_logalu_pkg;

  typedef enum logic {
    GF_OP_ADD = 1'b0,
    GF_OP_MUL = 1'b1
  } gfOp_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadFront;  // capture operands, look up logs
    logic loadBack;   // combine exponents, write result
  } gfStrobe_t;

endpackage

// File: rtl/gf_logalu_tables.sv
module gf_logalu_tables #(
  parameter int SYM_W = 8,
  parameter logic [SYM_W:0] PRIM_POLY = 'h11D
) (
  input  logic [SYM_W-1:0] vecIn  [2],
  output logic [SYM_W-1:0] logOut [2],
  input  logic [SYM_W-1:0] expIn,
  output logic [SYM_W-1:0] antiOut
);

  localparam int ELEMS    = 1 << SYM_W;
  localparam int ORDER    = ELEMS - 1;
  localparam int TBL_BITS = ELEMS * SYM_W;

  // antilog: entry i holds alpha^i in vector form, entry ORDER wraps to 1
  function automatic logic [TBL_BITS-1:0] buildAnti();
    logic [TBL_BITS-1:0] t;
    logic [SYM_W:0] v;
    t = '0;
    v = (SYM_W+1)'(1);
    for (int i = 0; i < ELEMS; i++) begin
      t[i*SYM_W +: SYM_W] = v[SYM_W-1:0];
      v = {v[SYM_W-1:0], 1'b0};
      if (v[SYM_W]) v = v ^ PRIM_POLY;
    end
    return t;
  endfunction

  // log: entry v holds the exponent of v; entry 0 keeps the all-ones marker
  function automatic logic [TBL_BITS-1:0] buildLog();
    logic [TBL_BITS-1:0] t;
    logic [SYM_W:0] v;
    t = '1;
    v = (SYM_W+1)'(1);
    for (int i = 0; i < ORDER; i++) begin
      t[int'(v[SYM_W-1:0])*SYM_W +: SYM_W] = SYM_W'(i);
      v = {v[SYM_W-1:0], 1'b0};
      if (v[SYM_W]) v = v ^ PRIM_POLY;
    end
    return t;
  endfunction

  localparam logic [TBL_BITS-1:0] ANTI_TBL = buildAnti();
  localparam logic [TBL_BITS-1:0] LOG_TBL  = buildLog();

  for (genvar g = 0; g < 2; g++) begin : g_logPort
    assign logOut[g] = LOG_TBL[int'(vecIn[g])*SYM_W +: SYM_W];
  end

  assign antiOut = ANTI_TBL[int'(expIn)*SYM_W +: SYM_W];

endmodule

// File: rtl/gf_logalu_ctrl.sv
module gf_logalu_ctrl
  import gf_logalu_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      inValid,
  output gfStrobe_t strobe,
  output logic      outValid
);

  logic frontValid;
  logic backValid;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      frontValid <= 1'b0;
      backValid  <= 1'b0;
    end else begin
      frontValid <= inValid;
      backValid  <= frontValid;
    end
  end

  always_comb begin
    strobe.loadFront = inValid;
    strobe.loadBack  = frontValid;
  end

  assign outValid = backValid;

  // R5: nothing completes unless the front stage held an operation
  a_r5_back_needs_front: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $past(strobe.loadBack));

endmodule

// File: rtl/gf_logalu_dp.sv
module gf_logalu_dp
  import gf_logalu_pkg::*;
#(
  parameter int SYM_W = 8,
  parameter logic [SYM_W:0] PRIM_POLY = 'h11D
) (
  input  logic             clk,
  input  logic             rstN,
  input  gfStrobe_t        strobe,
  input  gfOp_e            opSel,
  input  logic [SYM_W-1:0] opA,
  input  logic [SYM_W-1:0] opB,
  output logic [SYM_W-1:0] result
);

  localparam int ORDER = (1 << SYM_W) - 1;
  localparam logic [SYM_W:0] ORDER_W = (SYM_W+1)'(ORDER);

  logic [SYM_W-1:0] vecIn  [2];
  logic [SYM_W-1:0] logOut [2];
  logic [SYM_W-1:0] expIdx;
  logic [SYM_W-1:0] antiVal;

  gfOp_e            s1Op;
  logic             s1Zero;
  logic [SYM_W-1:0] s1Xor;
  logic [SYM_W-1:0] s1LogA;
  logic [SYM_W-1:0] s1LogB;

  logic [SYM_W:0]   expSum;
  logic [SYM_W:0]   expRed;
  logic [SYM_W-1:0] nextResult;

  assign vecIn[0] = opA;
  assign vecIn[1] = opB;

  gf_logalu_tables #(.SYM_W(SYM_W), .PRIM_POLY(PRIM_POLY)) u_tables (
    .vecIn  (vecIn),
    .logOut (logOut),
    .expIn  (expIdx),
    .antiOut(antiVal)
  );

  // front stage: logs, sum and zero detection
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      s1Op   <= GF_OP_ADD;
      s1Zero <= 1'b0;
      s1Xor  <= '0;
      s1LogA <= '0;
      s1LogB <= '0;
    end else if (strobe.loadFront) begin
      s1Op   <= opSel;
      s1Zero <= (opA == '0) || (opB == '0);
      s1Xor  <= opA ^ opB;
      s1LogA <= logOut[0];
      s1LogB <= logOut[1];
    end
  end

  // back stage: modular exponent sum and antilog
  always_comb begin
    expSum = {1'b0, s1LogA} + {1'b0, s1LogB};
    expRed = (expSum >= ORDER_W) ? (expSum - ORDER_W) : expSum;
    expIdx = expRed[SYM_W-1:0];
    if (s1Op == GF_OP_ADD)  nextResult = s1Xor;
    else if (s1Zero)        nextResult = '0;
    else                    nextResult = antiVal;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                result <= '0;
    else if (strobe.loadBack) result <= nextResult;
  end

  // R4: a reduced exponent of a real product lies below 2^m-1
  a_r4_exp_reduced: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.loadBack && s1Op == GF_OP_MUL && !s1Zero) |-> (expRed < ORDER_W));

  // R3: a product with a zero operand is written as zero
  a_r3_zero_product: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.loadBack && s1Op == GF_OP_MUL && s1Zero) |=> (result == '0));

  // R9: result only moves when the back stage loads
  a_r9_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.loadBack |=> $stable(result));

endmodule

// File: rtl/gf_logalu.sv
module gf_logalu
  import gf_logalu_pkg::*;
#(
  parameter int SYM_W = 8,
  parameter logic [SYM_W:0] PRIM_POLY = 'h11D
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic             opSel,
  input  logic [SYM_W-1:0] opA,
  input  logic [SYM_W-1:0] opB,
  output logic             outValid,
  output logic [SYM_W-1:0] outResult
);

  gfStrobe_t strobe;

  gf_logalu_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .strobe  (strobe),
    .outValid(outValid)
  );

  gf_logalu_dp #(.SYM_W(SYM_W), .PRIM_POLY(PRIM_POLY)) u_dp (
    .clk   (clk),
    .rstN  (rstN),
    .strobe(strobe),
    .opSel (gfOp_e'(opSel)),
    .opA   (opA),
    .opB   (opB),
    .result(outResult)
  );

  // R5: fixed two-cycle latency at the ports
  a_r5_latency: assert property (@(posedge clk) disable iff (!rstN)
    outValid == $past(inValid, 2));

  // R1: an add returns the XOR of the operands issued two cycles earlier
  a_r1_add_xor: assert property (@(posedge clk) disable iff (!rstN)
    $past(inValid && !opSel, 2) |-> (outResult == $past(opA ^ opB, 2)));

  // R7: multiplying by one is the identity
  a_r7_mul_one: assert property (@(posedge clk) disable iff (!rstN)
    $past(inValid && opSel && (opB == SYM_W'(1)), 2) |-> (outResult == $past(opA, 2)));

endmodule

// File: tb/test_gf_logalu.sv
module test_gf_logalu;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #5 clk = ~clk;

  logic       v8 = 1'b0, op8 = 1'b0;
  logic [7:0] a8 = '0, b8 = '0;
  logic       ov8;
  logic [7:0] r8;
  logic       v3 = 1'b0, op3 = 1'b0;
  logic [2:0] a3 = '0, b3 = '0;
  logic       ov3;
  logic [2:0] r3;

  gf_logalu #(.SYM_W(8), .PRIM_POLY(9'h11D)) i_gf_logalu (
    .clk(clk), .rstN(rstN), .inValid(v8), .opSel(op8), .opA(a8), .opB(b8),
    .outValid(ov8), .outResult(r8));

  gf_logalu #(.SYM_W(3), .PRIM_POLY(4'hB)) i_gf_logalu_m3 (
    .clk(clk), .rstN(rstN), .inValid(v3), .opSel(op3), .opA(a3), .opB(b3),
    .outValid(ov3), .outResult(r3));

  typedef struct packed { logic [7:0] a; logic [7:0] b; logic op; } ent_t;

  ent_t q8[$];
  ent_t q3[$];
  logic [1:0] hist8 = '0, hist3 = '0;
  logic [7:0] last8 = '0;
  logic [2:0] last3 = '0;
  int total = 0;
  int bad = 0;
  bit done = 0;

  function automatic int refMul(int a, int b, int m, int poly);
    int p = 0;
    int aa = a;
    for (int i = 0; i < m; i++) begin
      if (((b >> i) & 1) != 0) p = p ^ aa;
      aa = aa << 1;
      if ((aa & (1 << m)) != 0) aa = aa ^ poly;
    end
    return p;
  endfunction

  function automatic int alphaPow(int e, int m, int poly);
    int v = 1;
    for (int i = 0; i < e; i++) v = refMul(v, 2, m, poly);
    return v;
  endfunction

  task automatic chk(string tag, int got, int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s got=%0d exp=%0d", tag, got, exp);
    end
  endtask

  task automatic scoreOne(int m, int poly, logic ov, int res, ref ent_t q[$],
                          ref logic [1:0] hist, inout int last);
    ent_t e;
    int exp;
    string tag;
    chk($sformatf("R5 m=%0d valid", m), int'(ov), int'(hist[1]));
    if (ov) begin
      if (q.size() == 0) chk($sformatf("R5 m=%0d spurious", m), 1, 0);
      else begin
        e = q.pop_front();
        if (!e.op) begin exp = int'(e.a) ^ int'(e.b); tag = "R1"; end
        else begin
          exp = refMul(int'(e.a), int'(e.b), m, poly);
          tag = (e.a == 0 || e.b == 0) ? "R3" : "R2";
        end
        chk($sformatf("%s m=%0d a=%0d b=%0d op=%0d", tag, m, e.a, e.b, e.op), res, exp);
      end
      last = res;
    end else begin
      chk($sformatf("R9 m=%0d hold", m), res, last);
    end
  endtask

  task automatic cycle(logic nv8, logic nop8, logic [7:0] na8, logic [7:0] nb8,
                       logic nv3, logic nop3, logic [2:0] na3, logic [2:0] nb3);
    int l8, l3;
    @(negedge clk);
    l8 = int'(last8); l3 = int'(last3);
    scoreOne(8, 'h11D, ov8, int'(r8), q8, hist8, l8);
    scoreOne(3, 'hB, ov3, int'(r3), q3, hist3, l3);
    last8 = l8[7:0]; last3 = l3[2:0];
    v8 = nv8; op8 = nop8; a8 = na8; b8 = nb8;
    v3 = nv3; op3 = nop3; a3 = na3; b3 = nb3;
    if (nv8) q8.push_back({na8, nb8, nop8});
    if (nv3) q3.push_back({5'd0, na3, 5'd0, nb3, nop3});
    hist8 = {hist8[0], nv8};
    hist3 = {hist3[0], nv3};
  endtask

  task automatic op3Wait(logic op, int a, int b, output int res);
    cycle(0, 0, 0, 0, 1, op, a[2:0], b[2:0]);
    cycle(0, 0, 0, 0, 0, 0, 0, 0);
    cycle(0, 0, 0, 0, 0, 0, 0, 0);
    res = int'(r3);
  endtask

  task automatic op8Wait(logic op, int a, int b, output int res);
    cycle(1, op, a[7:0], b[7:0], 0, 0, 0, 0);
    cycle(0, 0, 0, 0, 0, 0, 0, 0);
    cycle(0, 0, 0, 0, 0, 0, 0, 0);
    res = int'(r8);
  endtask

  initial begin
    int res, p, s, c;
    int seq[7] = '{2, 4, 3, 6, 7, 5, 1};
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R5 reset valid m=8", int'(ov8), 0);
    chk("R5 reset valid m=3", int'(ov3), 0);
    rstN = 1'b1;

    // m=3 exhaustive, add and multiply interleaved back to back (R1 R2 R3)
    for (int a = 0; a < 8; a++)
      for (int b = 0; b < 8; b++)
        for (int o = 0; o < 2; o++)
          cycle(0, 0, 0, 0, 1, o[0], a[2:0], b[2:0]);
    repeat (3) cycle(0, 0, 0, 0, 0, 0, 0, 0);

    // R6: powers of alpha
    p = 1;
    for (int i = 0; i < 7; i++) begin
      op3Wait(1, p, 2, res);
      chk($sformatf("R6 alpha^%0d", i + 1), res, seq[i]);
      p = res;
    end

    // R8: alpha * (alpha^3 + alpha^5)^3
    op3Wait(0, 3, 7, s);
    op3Wait(1, s, s, c);
    op3Wait(1, c, s, c);
    op3Wait(1, 2, c, res);
    chk("R8 worked example", res, 1);

    // R7: multiply by one
    op8Wait(1, 'hA7, 1, res);
    chk("R7 a*1 m=8", res, 'hA7);
    op3Wait(1, 5, 1, res);
    chk("R7 a*1 m=3", res, 5);

    // R4: exponent wrap
    op8Wait(1, alphaPow(254, 8, 'h11D), alphaPow(254, 8, 'h11D), res);
    chk("R4 a^254*a^254", res, alphaPow(253, 8, 'h11D));
    op8Wait(1, 2, alphaPow(254, 8, 'h11D), res);
    chk("R4 a*a^254", res, 1);

    // m=8 exhaustive multiply stream (R2 R3)
    for (int a = 0; a < 256; a++)
      for (int b = 0; b < 256; b++)
        cycle(1, 1, a[7:0], b[7:0], 0, 0, 0, 0);

    // m=8 random mix with bubbles (R1 R2 R3 R5 R9)
    for (int i = 0; i < 3000; i++) begin
      int sel = int'($urandom % 8);
      logic [7:0] ra = 8'($urandom);
      logic [7:0] rb = 8'($urandom);
      if (sel == 0) ra = 8'd0;
      if (sel == 1) rb = 8'd1;
      cycle(($urandom % 4) != 0, 1'($urandom), ra, rb, 0, 0, 0, 0);
    end
    repeat (4) cycle(0, 0, 0, 0, 0, 0, 0, 0);
    chk("R5 queue drained m=8", q8.size(), 0);
    chk("R5 queue drained m=3", q3.size(), 0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule